// File: doc/BRIEF.md
# Video-Priority VRAM Arbiter

This block shares one single-ported video memory, 16 bits per word, among a scan-out fetcher and a set of secondary masters. The memory performs at most one access per pixel clock. The scan-out fetcher owns every cycle in which it asks for data. The secondary masters are an audio/sprite line-buffer DMA, a display-list coprocessor, a block-copy engine and a host port. They share only the cycles the fetcher leaves idle, for example the long stretch of cycles before the first visible pixel of each line.

Each secondary master drives its own request, write enable, word address and write data. It holds them steady until its grant comes back. A grant is combinational in the cycle of the access. A write is committed at the end of that cycle. A read returns its word on a shared read-data bus one clock later, together with a valid pulse that goes only to the master that issued the read.

The address width is a parameter. Its default keeps the memory model small; set `ADDR_W` to 16 for the full 64K-word space. A visibility input marks the active part of the line and feeds only the protocol checks.

Top module: `vram_arb`

## Requirements
- R1: When `vid_req_i` is high, `vid_gnt_o` is high in the same cycle and the memory reads `vid_addr_i`.
- R2: No secondary grant is given in a cycle where `vid_req_i` is high. With a fetch pending on every visible cycle, the secondary masters receive no grant for the whole visible region.
- R3: At most one of `vid_gnt_o` and the `sec_gnt_o` bits is high in any cycle.
- R4: Among secondary masters, a lower index wins: bit 0 (audio/sprite DMA) beats bit 1 (coprocessor), which beats bit 2 (block copy), which beats bit 3 (host port).
- R5: In a cycle with `vid_req_i` low and any `sec_req_i` bit high, exactly one secondary master is granted.
- R6: A read granted in cycle t places its word on `rdata_o` in cycle t+1, with a one-cycle pulse on the matching valid output (`vid_rvalid_o`, or bit i of `sec_rvalid_o`) and on no other valid output.
- R7: A granted write (`sec_we_i` bit = 1) stores its data at its address in the granted cycle and raises no valid pulse. Any later read of that address, by any master, returns the new word.
- R8: A request that is stalled and never granted leaves memory unchanged. A video read of the same address during the stall returns the old word.
- R9: After reset, all valid outputs are low until a read is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vis_i | input | 1 | High during the visible part of the line |
| vid_req_i | input | 1 | Scan-out fetch request |
| vid_addr_i | input | ADDR_W | Scan-out word address |
| vid_gnt_o | output | 1 | Scan-out grant |
| vid_rvalid_o | output | 1 | Scan-out read data valid |
| sec_req_i | input | N_SEC | Secondary requests, bit index = priority rank |
| sec_we_i | input | N_SEC | Secondary write enables |
| sec_addr_i | input | N_SEC*ADDR_W | Secondary word addresses, master i at slice i |
| sec_wdata_i | input | N_SEC*DATA_W | Secondary write data, master i at slice i |
| sec_gnt_o | output | N_SEC | Secondary grants |
| sec_rvalid_o | output | N_SEC | Secondary read data valid |
| rdata_o | output | DATA_W | Shared read data |

## Verification
On every cycle the assertions check the following: grants are exclusive, no secondary grant appears beside a pending fetch or during a visible fetch, the priority chain holds, no idle cycle occurs while a secondary master waits, and each valid pulse follows its own read grant. Data integrity cannot be shown by per-cycle properties. A write must land in the right cycle, a read must return the right word, and a long stalled write must leave memory untouched. These are shown by the bench's queue-based model, which compares grants and read data every cycle across stall, drain, interleaved and back-to-back same-address scenarios.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned N_SEC_DEF  = 4;
  // secondary index = priority rank, 0 highest
  typedef enum int unsigned {
    SEC_DMA  = 0,
    SEC_COP  = 1,
    SEC_BLIT = 2,
    SEC_HOST = 3
  } sec_id_e;
endpackage

// File: rtl/vram_prio_pick.sv
module vram_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]     = req_i[i] & ~taken[i];
    assign taken[i + 1] = taken[i] | req_i[i];
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5
    gnt_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[i] |-> req_i[i]);
    if (i > 0) begin : g_hi
      // R4
      prio_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt_o[i] |-> (req_i[i-1:0] == '0));
    end
  end
endmodule

// File: rtl/vram_sram.sv
module vram_sram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 11,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      else      rdata_o     <= mem[addr_i];
    end
  end
endmodule

// File: rtl/vram_arb.sv
module vram_arb
  import vram_arb_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned N_SEC  = N_SEC_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vis_i,
  input  logic                     vid_req_i,
  input  logic [ADDR_W-1:0]        vid_addr_i,
  output logic                     vid_gnt_o,
  output logic                     vid_rvalid_o,
  input  logic [N_SEC-1:0]         sec_req_i,
  input  logic [N_SEC-1:0]         sec_we_i,
  input  logic [N_SEC*ADDR_W-1:0]  sec_addr_i,
  input  logic [N_SEC*DATA_W-1:0]  sec_wdata_i,
  output logic [N_SEC-1:0]         sec_gnt_o,
  output logic [N_SEC-1:0]         sec_rvalid_o,
  output logic [DATA_W-1:0]        rdata_o
);
  logic [N_SEC-1:0]  sec_open;
  logic              mem_en;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  // secondary masters only see cycles the fetcher leaves idle
  assign sec_open  = sec_req_i & {N_SEC{~vid_req_i}};
  assign vid_gnt_o = vid_req_i;

  vram_prio_pick #(.N(N_SEC)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (sec_open),
    .gnt_o  (sec_gnt_o)
  );

  always_comb begin
    mem_en    = vid_req_i | (|sec_gnt_o);
    mem_we    = 1'b0;
    mem_addr  = vid_addr_i;
    mem_wdata = '0;
    for (int i = 0; i < N_SEC; i++) begin
      if (sec_gnt_o[i]) begin
        mem_we    = sec_we_i[i];
        mem_addr  = sec_addr_i[i*ADDR_W +: ADDR_W];
        mem_wdata = sec_wdata_i[i*DATA_W +: DATA_W];
      end
    end
  end

  vram_sram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_rvalid_o <= 1'b0;
      sec_rvalid_o <= '0;
    end else begin
      vid_rvalid_o <= vid_gnt_o;
      sec_rvalid_o <= sec_gnt_o & ~sec_we_i;
    end
  end

  // R3
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vid_gnt_o, sec_gnt_o}));
  // R2
  vid_blocks_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_req_i |-> (sec_gnt_o == '0));
  // R2
  visible_no_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vis_i && vid_req_i) |-> !(|sec_gnt_o));
  // R5
  no_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vid_req_i && (|sec_req_i)) |-> $onehot(sec_gnt_o));
  // R6
  vid_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_gnt_o |=> vid_rvalid_o);
  // R6
  one_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vid_rvalid_o, sec_rvalid_o}));
  for (genvar i = 0; i < N_SEC; i++) begin : g_rv_chk
    // R6
    sec_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sec_gnt_o[i] && !sec_we_i[i]) |=> sec_rvalid_o[i]);
    // R7
    wr_no_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sec_gnt_o[i] && sec_we_i[i]) |=> !sec_rvalid_o[i]);
  end
endmodule

// File: tb/vram_arb_tb.sv
module vram_arb_tb;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int NS = 4;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } op_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vis = 1'b0;
  logic vid_req = 1'b0;
  logic [AW-1:0] vid_addr = '0;
  logic vid_gnt, vid_rvalid;
  logic [NS-1:0] sec_req = '0, sec_we = '0, sec_gnt, sec_rvalid;
  logic [NS*AW-1:0] sec_addr = '0;
  logic [NS*DW-1:0] sec_wdata = '0;
  logic [DW-1:0] rdata;

  always #2 clk = ~clk;

  vram_arb #(.DATA_W(DW), .ADDR_W(AW), .N_SEC(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vis_i(vis),
    .vid_req_i(vid_req), .vid_addr_i(vid_addr),
    .vid_gnt_o(vid_gnt), .vid_rvalid_o(vid_rvalid),
    .sec_req_i(sec_req), .sec_we_i(sec_we), .sec_addr_i(sec_addr),
    .sec_wdata_i(sec_wdata), .sec_gnt_o(sec_gnt), .sec_rvalid_o(sec_rvalid),
    .rdata_o(rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  op_t q0[$], q1[$], q2[$], q3[$];
  logic [DW-1:0] mdl [int];
  logic e_vrv = 1'b0;
  logic [NS-1:0] e_srv = '0;
  logic [DW-1:0] e_rd = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int qn(input int i);
    case (i)
      0: return q0.size();
      1: return q1.size();
      2: return q2.size();
      default: return q3.size();
    endcase
  endfunction

  function automatic op_t hd(input int i);
    if (qn(i) == 0) return '0;
    case (i)
      0: return q0[0];
      1: return q1[0];
      2: return q2[0];
      default: return q3[0];
    endcase
  endfunction

  task automatic pop(input int i);
    case (i)
      0: void'(q0.pop_front());
      1: void'(q1.pop_front());
      2: void'(q2.pop_front());
      default: void'(q3.pop_front());
    endcase
  endtask

  task automatic push(input int i, input logic we, input int a, input logic [DW-1:0] d);
    op_t o;
    o.we = we; o.addr = AW'(a); o.data = d;
    case (i)
      0: q0.push_back(o);
      1: q1.push_back(o);
      2: q2.push_back(o);
      default: q3.push_back(o);
    endcase
  endtask

  task automatic cycle(input logic v, input int va, input logic vs);
    op_t o;
    logic [NS:0] exp_g;
    int k;
    @(negedge clk);
    // R6 registered return of previous cycle's read
    chk({vid_rvalid, sec_rvalid} === {e_vrv, e_srv}, "R6 rvalid", {27'd0, vid_rvalid, sec_rvalid}, {27'd0, e_vrv, e_srv});
    if (e_vrv || (|e_srv))
      chk(rdata === e_rd, "R6/R7 rdata", {16'd0, rdata}, {16'd0, e_rd});
    vid_req = v; vid_addr = AW'(va); vis = vs;
    for (int i = 0; i < NS; i++) begin
      o = hd(i);
      sec_req[i] = qn(i) > 0;
      sec_we[i] = o.we;
      sec_addr[i*AW +: AW] = o.addr;
      sec_wdata[i*DW +: DW] = o.data;
    end
    #1;
    k = -1;
    if (!v) for (int i = NS - 1; i >= 0; i--) if (qn(i) > 0) k = i;
    exp_g = '0;
    if (v) exp_g[NS] = 1'b1;
    else if (k >= 0) exp_g[k] = 1'b1;
    if (v) chk({vid_gnt, sec_gnt} === exp_g, (|sec_req) ? "R2/R8 stall" : "R1 video grant", {27'd0, vid_gnt, sec_gnt}, {27'd0, exp_g});
    else   chk({vid_gnt, sec_gnt} === exp_g, "R4 priority", {27'd0, vid_gnt, sec_gnt}, {27'd0, exp_g});
    chk($onehot0({vid_gnt, sec_gnt}), "R3 exclusive", {27'd0, vid_gnt, sec_gnt}, {27'd0, exp_g});
    if (!v && (|sec_req))
      chk($countones(sec_gnt) == 1, "R5 no idle", {28'd0, sec_gnt}, {27'd0, exp_g});
    e_vrv = v; e_srv = '0;
    if (v) begin
      e_rd = mdl.exists(int'(AW'(va))) ? mdl[int'(AW'(va))] : 'x;
    end else if (k >= 0) begin
      o = hd(k);
      if (o.we) mdl[int'(o.addr)] = o.data;
      else begin
        e_srv[k] = 1'b1;
        e_rd = mdl[int'(o.addr)];
      end
      pop(k);
    end
  endtask

  task automatic drain();
    while (qn(0) + qn(1) + qn(2) + qn(3) > 0) cycle(1'b0, 0, 1'b0);
    cycle(1'b0, 0, 1'b0);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk({vid_rvalid, sec_rvalid} === '0, "R9 reset valid", {27'd0, vid_rvalid, sec_rvalid}, 32'd0);

    // R7 R5: host fills memory
    for (int a = 0; a < 16; a++) push(3, 1'b1, a, 16'hA000 + 16'(a));
    drain();

    // R4 R6: all four read at once
    push(0, 1'b0, 1, '0); push(1, 1'b0, 2, '0);
    push(2, 1'b0, 3, '0); push(3, 1'b0, 4, '0);
    drain();

    // R2 R8: visible region, fetch every cycle, writes stall
    push(3, 1'b1, 5, 16'hBEEF); push(0, 1'b1, 6, 16'h1234); push(1, 1'b0, 7, '0);
    for (int c = 0; c < 24; c++) cycle(1'b1, 5 + (c % 2), 1'b1);
    drain();
    // R7: stalled writes now visible
    cycle(1'b1, 5, 1'b0);
    cycle(1'b1, 6, 1'b0);
    cycle(1'b0, 0, 1'b0);

    // R7: back-to-back same address write then read
    push(2, 1'b1, 9, 16'h5555); push(3, 1'b0, 9, '0);
    drain();

    // mixed traffic, fetch on alternate cycles
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < NS; i++)
        push(i, ((i + j) % 2) == 0, (i * 3 + j) % 16, 16'(i * 256 + j * 17 + 1));
    for (int c = 0; c < 40; c++) cycle(c % 2 == 0, c % 16, 1'b0);
    drain();

    // mixed traffic, fetch two of three cycles
    for (int j = 0; j < 5; j++)
      for (int i = 0; i < NS; i++)
        push(i, (j % 3) == 1, (i + j * 5) % 16, 16'hC000 + 16'(i * 16 + j));
    for (int c = 0; c < 60; c++) cycle(c % 3 != 0, (c * 7) % 16, 1'b0);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule